// File: doc/BRIEF.md
# Three-dimensional DMA address sequencer

This block walks one transfer description through three nested dimensions: bytes per array, arrays per frame and frames per block. It turns each synchronization event into array requests. Every request carries the source byte address, the destination byte address and the byte count of one array. A downstream data mover performs the actual copy. The block only keeps the remaining counts and advances both addresses.

A record is presented on the parallel inputs together with a one-cycle load strobe. The record holds the mode bits, two base addresses, the three counts, a middle-count reload value and two stride words. After the load, each event strobe starts one step of the transfer. In array-synchronized mode a step is one array. In frame-synchronized mode a step is a whole frame, issued one array per cycle. The source and destination each have their own signed steps between arrays and between frames. Either side can be held at a constant address, as needed for a peripheral data register. A completion pulse marks the last array of the block. Misplaced events and unusable records raise a one-cycle error pulse.

Top module: `xfer3d_addr_seq`

## Requirements
- R1: The count word carries the bytes per array in bits 15:0 and the arrays per frame in bits 31:16. The frame count is its own 16-bit input. Every request shows the byte count of the loaded record on `req_len_o`, and this value does not change between requests of one record.
- R2: Each stride word holds a signed 16-bit source offset in bits 15:0 and a signed 16-bit destination offset in bits 31:16. `ofs_arr_i` is the byte step from one array to the next within a frame. `ofs_frm_i` is the byte step between frames.
- R3: After reset no request, completion or error is shown. With mode bit 2 at 0 (array-synchronized), each accepted event produces exactly one request. That request is visible in the cycle after the clock edge that samples the event.
- R4: In array-synchronized mode the first frame has the number of arrays given in the count word. Every later frame has the number given by `rld_i`.
- R5: In array-synchronized mode the first array of a new frame is at the address of the previous frame's last array plus the frame offset.
- R6: With mode bit 2 at 1 (frame-synchronized), one event produces all arrays of a frame, one per cycle on consecutive cycles. Every frame has the array count of the count word. Each frame begins at the previous frame's first address plus the frame offset.
- R7: Mode bit 0 holds the source address at its base value for the whole transfer. Mode bit 1 does the same for the destination address.
- R8: `done_o` is high together with the last request of the last frame, and only then. No request follows until a new record is loaded.
- R9: An event that is sampled while no usable record is loaded, after completion, or during a frame burst is ignored. It raises `err_o` for one cycle. A burst in progress continues unchanged.
- R10: A load is refused, with a one-cycle `err_o` and no request on later events, if it has any of the following zero values: the byte count, the array count, the frame count, or (in array-synchronized mode only) the reload count.
- R11: A load that is accepted while a transfer is in progress replaces it. The next event starts from the new base addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Load strobe for the record inputs |
| opt_i | input | 3 | Mode: bit 0 source hold, bit 1 destination hold, bit 2 frame-synchronized |
| src_i | input | ADDR_W | Source base address |
| dst_i | input | ADDR_W | Destination base address |
| cnt_ab_i | input | 2*CNT_W | Bytes per array [15:0], arrays per frame [31:16] |
| cnt_c_i | input | CNT_W | Frames per block |
| rld_i | input | CNT_W | Arrays per frame after the first frame (array-synchronized) |
| ofs_arr_i | input | 2*OFS_W | Array step: source [15:0], destination [31:16] |
| ofs_frm_i | input | 2*OFS_W | Frame step: source [15:0], destination [31:16] |
| evt_i | input | 1 | Synchronization event strobe |
| req_vld_o | output | 1 | Array request valid |
| req_src_o | output | ADDR_W | Source address of the request |
| req_dst_o | output | ADDR_W | Destination address of the request |
| req_len_o | output | CNT_W | Byte count of the request |
| done_o | output | 1 | Completion pulse, with the final request |
| err_o | output | 1 | Pulse for an ignored event or a refused record |

## Verification
A wrong remaining-array count shows up at the ports within the frame in progress. The frame step lands on the wrong array, or a burst in frame-synchronized mode has the wrong length. A wrong remaining-frame count moves the completion pulse or lets requests continue after it. A corrupted frame-start or current address shows on the very next request address. The bench therefore compares every request of each scenario against a model built from the requirements. It also checks for silence in the cycle after each completion.

// File: rtl/xfer3d_pkg.sv
package xfer3d_pkg;
  // mode bit positions (the per-axis hold bits are indexed by axis number)
  localparam int OPT_W          = 3;
  localparam int OPT_SRC_HOLD   = 0;
  localparam int OPT_DST_HOLD   = 1;
  localparam int OPT_FRAME_SYNC = 2;
  localparam int NAX            = 2;   // axis 0 = source, axis 1 = destination

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_BURST = 2'd2
  } seq_st_e;
endpackage

// File: rtl/xfer3d_ctl.sv
module xfer3d_ctl
  import xfer3d_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic             frame_i,
  input  logic             len_ok_i,
  input  logic [CNT_W-1:0] b_cnt_i,
  input  logic [CNT_W-1:0] c_cnt_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic             evt_i,
  output logic             accept_o,
  output logic             fire_o,
  output logic             step_arr_o,
  output logic             step_frm_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] arr_q, arr_d;
  logic [CNT_W-1:0] frm_q, frm_d;
  logic [CNT_W-1:0] binit_q, binit_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             frame_q, frame_d;
  logic             rec_ok, last_arr, last_frm, upd;

  always_comb begin
    rec_ok   = (b_cnt_i != '0) && (c_cnt_i != '0) && len_ok_i &&
               (frame_i || (rld_i != '0));
    accept_o = ld_i && rec_ok;
    fire_o   = !ld_i && (((st_q == ST_READY) && evt_i) || (st_q == ST_BURST));
    last_arr = (arr_q == ONE);
    last_frm = last_arr && (frm_q == ONE);
    step_arr_o = fire_o && !last_arr;
    step_frm_o = fire_o && last_arr;
    done_o     = fire_o && last_frm;
    err_o      = (ld_i && !rec_ok) || (!ld_i && evt_i && (st_q != ST_READY));
    upd        = ld_i || fire_o;
  end

  always_comb begin
    st_d    = st_q;
    arr_d   = arr_q;
    frm_d   = frm_q;
    binit_d = binit_q;
    rld_d   = rld_q;
    frame_d = frame_q;
    if (ld_i) begin
      if (rec_ok) begin
        st_d    = ST_READY;
        arr_d   = b_cnt_i;
        frm_d   = c_cnt_i;
        binit_d = b_cnt_i;
        rld_d   = rld_i;
        frame_d = frame_i;
      end else begin
        st_d    = ST_IDLE;
      end
    end else if (fire_o) begin
      if (last_arr) begin
        arr_d = frame_q ? binit_q : rld_q;
        frm_d = frm_q - ONE;
        st_d  = last_frm ? ST_IDLE : ST_READY;
      end else begin
        arr_d = arr_q - ONE;
        st_d  = frame_q ? ST_BURST : ST_READY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      arr_q   <= '0;
      frm_q   <= '0;
      binit_q <= '0;
      rld_q   <= '0;
      frame_q <= 1'b0;
    end else if (upd) begin
      st_q    <= st_d;
      arr_q   <= arr_d;
      frm_q   <= frm_d;
      binit_q <= binit_d;
      rld_q   <= rld_d;
      frame_q <= frame_d;
    end
  end
endmodule

// File: rtl/xfer3d_axis.sv
module xfer3d_axis #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  arr_ofs_i,
  input  logic [OFS_W-1:0]  frm_ofs_i,
  input  logic              hold_i,
  input  logic              frame_i,
  input  logic              step_arr_i,
  input  logic              step_frm_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] cur_q, cur_d, fs_q, fs_d;
  logic [OFS_W-1:0]  aofs_q, aofs_d, fofs_q, fofs_d;
  logic              hold_q, hold_d, frame_q, frame_d;
  logic [ADDR_W-1:0] aofs_x, fofs_x;
  logic              en;

  assign aofs_x = {{EXT_W{aofs_q[OFS_W-1]}}, aofs_q};
  assign fofs_x = {{EXT_W{fofs_q[OFS_W-1]}}, fofs_q};
  assign en     = ld_i || step_arr_i || step_frm_i;

  always_comb begin
    cur_d   = cur_q;
    fs_d    = fs_q;
    aofs_d  = aofs_q;
    fofs_d  = fofs_q;
    hold_d  = hold_q;
    frame_d = frame_q;
    if (ld_i) begin
      cur_d   = base_i;
      fs_d    = base_i;
      aofs_d  = arr_ofs_i;
      fofs_d  = frm_ofs_i;
      hold_d  = hold_i;
      frame_d = frame_i;
    end else if (!hold_q) begin
      if (step_arr_i) begin
        cur_d = cur_q + aofs_x;
      end else if (step_frm_i) begin
        // frame-synchronized: from frame start; array-synchronized: from last array
        cur_d = (frame_q ? fs_q : cur_q) + fofs_x;
        fs_d  = cur_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      fs_q    <= '0;
      aofs_q  <= '0;
      fofs_q  <= '0;
      hold_q  <= 1'b0;
      frame_q <= 1'b0;
    end else if (en) begin
      cur_q   <= cur_d;
      fs_q    <= fs_d;
      aofs_q  <= aofs_d;
      fofs_q  <= fofs_d;
      hold_q  <= hold_d;
      frame_q <= frame_d;
    end
  end

  assign addr_o = cur_q;
endmodule

// File: rtl/xfer3d_addr_seq.sv
module xfer3d_addr_seq
  import xfer3d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_i,
  input  logic [OPT_W-1:0]     opt_i,
  input  logic [ADDR_W-1:0]    src_i,
  input  logic [ADDR_W-1:0]    dst_i,
  input  logic [2*CNT_W-1:0]   cnt_ab_i,
  input  logic [CNT_W-1:0]     cnt_c_i,
  input  logic [CNT_W-1:0]     rld_i,
  input  logic [NAX*OFS_W-1:0] ofs_arr_i,
  input  logic [NAX*OFS_W-1:0] ofs_frm_i,
  input  logic                 evt_i,
  output logic                 req_vld_o,
  output logic [ADDR_W-1:0]    req_src_o,
  output logic [ADDR_W-1:0]    req_dst_o,
  output logic [CNT_W-1:0]     req_len_o,
  output logic                 done_o,
  output logic                 err_o
);
  logic                         accept, fire, step_arr, step_frm, done_c, err_c;
  logic [NAX-1:0][ADDR_W-1:0]   base_w;
  logic [NAX-1:0][ADDR_W-1:0]   ax_addr;
  logic [CNT_W-1:0]             len_byte;
  logic [CNT_W-1:0]             len_arr;
  logic                         vld_q, done_q, err_q;
  logic [ADDR_W-1:0]            src_q, dst_q;
  logic [CNT_W-1:0]             len_q;

  assign len_byte  = cnt_ab_i[CNT_W-1:0];
  assign len_arr   = cnt_ab_i[2*CNT_W-1:CNT_W];
  assign base_w[0] = src_i;
  assign base_w[1] = dst_i;

  xfer3d_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_i       (ld_i),
    .frame_i    (opt_i[OPT_FRAME_SYNC]),
    .len_ok_i   (len_byte != '0),
    .b_cnt_i    (len_arr),
    .c_cnt_i    (cnt_c_i),
    .rld_i      (rld_i),
    .evt_i      (evt_i),
    .accept_o   (accept),
    .fire_o     (fire),
    .step_arr_o (step_arr),
    .step_frm_o (step_frm),
    .done_o     (done_c),
    .err_o      (err_c)
  );

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    xfer3d_axis #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_axis (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_i       (accept),
      .base_i     (base_w[g]),
      .arr_ofs_i  (ofs_arr_i[g*OFS_W +: OFS_W]),
      .frm_ofs_i  (ofs_frm_i[g*OFS_W +: OFS_W]),
      .hold_i     (opt_i[OPT_SRC_HOLD + g]),
      .frame_i    (opt_i[OPT_FRAME_SYNC]),
      .step_arr_i (step_arr),
      .step_frm_i (step_frm),
      .addr_o     (ax_addr[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q  <= fire;
      done_q <= done_c;
      err_q  <= err_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (fire) begin
      src_q <= ax_addr[0];
      dst_q <= ax_addr[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (accept) begin
      len_q <= len_byte;
    end
  end

  assign req_vld_o = vld_q;
  assign req_src_o = src_q;
  assign req_dst_o = dst_q;
  assign req_len_o = len_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/xfer3d_chk.sv
module xfer3d_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_i,
  input logic             req_vld_o,
  input logic [CNT_W-1:0] req_len_o,
  input logic             done_o,
  input logic             err_o
);
  // R8: completion accompanies a request
  p_done_has_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> req_vld_o);

  // R8: nothing is requested in the cycle after completion
  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !req_vld_o);

  // R1: byte count stays fixed across back-to-back requests
  p_len_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_o && $past(req_vld_o)) |-> $stable(req_len_o));

  // R10: a refused record produces no request afterwards
  p_refused_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && $past(ld_i)) |=> !req_vld_o);
endmodule

bind xfer3d_addr_seq xfer3d_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_i      (ld_i),
  .req_vld_o (req_vld_o),
  .req_len_o (req_len_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/tb_xfer3d_addr_seq.sv
module tb_xfer3d_addr_seq;
  localparam int AW = 32;
  localparam int OW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_i;
  logic [2:0]    opt_i;
  logic [AW-1:0] src_i, dst_i;
  logic [2*CW-1:0] cnt_ab_i;
  logic [CW-1:0] cnt_c_i, rld_i;
  logic [2*OW-1:0] ofs_arr_i, ofs_frm_i;
  logic          evt_i;
  logic          req_vld_o, done_o, err_o;
  logic [AW-1:0] req_src_o, req_dst_o;
  logic [CW-1:0] req_len_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  xfer3d_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .opt_i(opt_i), .src_i(src_i), .dst_i(dst_i),
    .cnt_ab_i(cnt_ab_i), .cnt_c_i(cnt_c_i), .rld_i(rld_i), .ofs_arr_i(ofs_arr_i),
    .ofs_frm_i(ofs_frm_i), .evt_i(evt_i), .req_vld_o(req_vld_o), .req_src_o(req_src_o),
    .req_dst_o(req_dst_o), .req_len_o(req_len_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load_set(input logic [2:0] opt, input logic [31:0] s, input logic [31:0] d,
                          input logic [15:0] len, input logic [15:0] b, input logic [15:0] c,
                          input logic [15:0] rld, input logic [31:0] oa, input logic [31:0] of);
    opt_i = opt; src_i = s; dst_i = d; cnt_ab_i = {b, len}; cnt_c_i = c;
    rld_i = rld; ofs_arr_i = oa; ofs_frm_i = of; ld_i = 1'b1;
    @(negedge clk);
    ld_i = 1'b0;
  endtask

  task automatic evt_pulse();
    evt_i = 1'b1;
    @(negedge clk);
    evt_i = 1'b0;
  endtask

  // loads a record and walks it, comparing every request against a model
  task automatic run_set(input string tag, input logic [2:0] opt, input logic [31:0] s,
                         input logic [31:0] d, input logic [15:0] len, input logic [15:0] b,
                         input logic [15:0] c, input logic [15:0] rld,
                         input logic [31:0] oa, input logic [31:0] of);
    logic [31:0] s_cur, s_fs, d_cur, d_fs;
    bit frm, hs, hd;
    frm = opt[2]; hs = opt[0]; hd = opt[1];
    s_cur = s; s_fs = s; d_cur = d; d_fs = d;
    load_set(opt, s, d, len, b, c, rld, oa, of);
    chk({tag, " R10 load accepted err"}, 32'(err_o), 32'd0);
    for (int f = 0; f < int'(c); f++) begin
      int nb;
      nb = (f == 0 || frm) ? int'(b) : int'(rld);
      if (frm) evt_i = 1'b1;
      for (int a = 0; a < nb; a++) begin
        bit last_a, last_f;
        if (!frm) evt_i = 1'b1;
        @(negedge clk);
        evt_i = 1'b0;
        last_a = (a == nb - 1);
        last_f = (f == int'(c) - 1);
        chk({tag, " vld"}, 32'(req_vld_o), 32'd1);
        chk({tag, " src"}, req_src_o, s_cur);
        chk({tag, " dst"}, req_dst_o, d_cur);
        chk({tag, " R1 len"}, 32'(req_len_o), 32'(len));
        chk({tag, " R8 done"}, 32'(done_o), 32'(last_a && last_f));
        chk({tag, " R9 err"}, 32'(err_o), 32'd0);
        if (!last_a) begin
          if (!hs) s_cur = s_cur + sx(oa[15:0]);
          if (!hd) d_cur = d_cur + sx(oa[31:16]);
        end else begin
          if (!hs) begin s_cur = (frm ? s_fs : s_cur) + sx(of[15:0]);  s_fs = s_cur; end
          if (!hd) begin d_cur = (frm ? d_fs : d_cur) + sx(of[31:16]); d_fs = d_cur; end
        end
      end
    end
    @(negedge clk);
    chk({tag, " R8 quiet after done"}, 32'(req_vld_o), 32'd0);
  endtask

  task automatic t_reset();
    chk("R3 reset vld", 32'(req_vld_o), 32'd0);
    chk("R3 reset done", 32'(done_o), 32'd0);
    chk("R3 reset err", 32'(err_o), 32'd0);
    evt_pulse();
    chk("R9 event before load err", 32'(err_o), 32'd1);
    chk("R9 event before load no req", 32'(req_vld_o), 32'd0);
  endtask

  task automatic t_array();
    // 3 arrays then 2 (reload), source +16/+100, destination -8/+64
    run_set("R1 R2 R3 R4 R5 array", 3'b000, 32'h1000, 32'h8000, 16'd4, 16'd3, 16'd2,
            16'd2, {16'hFFF8, 16'h0010}, {16'h0040, 16'h0064});
    // check one gap between events shows no request (R3)
    load_set(3'b000, 32'h40, 32'h80, 16'd2, 16'd2, 16'd1, 16'd1, 32'h0004_0004, 32'h0);
    evt_pulse();
    chk("R3 one req per event", 32'(req_vld_o), 32'd1);
    @(negedge clk);
    chk("R3 no req without event", 32'(req_vld_o), 32'd0);
  endtask

  task automatic t_frame();
    run_set("R2 R6 frame", 3'b100, 32'h2000, 32'h9000, 16'd8, 16'd3, 16'd3, 16'd5,
            {16'hFFFC, 16'h0004}, {16'hFF00, 16'h0020});
  endtask

  task automatic t_hold();
    run_set("R7 src hold", 3'b101, 32'h3000, 32'hA000, 16'd4, 16'd3, 16'd2, 16'd0,
            {16'h0004, 16'h0004}, {16'h0100, 16'h0100});
    run_set("R7 dst hold", 3'b010, 32'h3100, 32'hB000, 16'd4, 16'd2, 16'd2, 16'd2,
            {16'h0008, 16'h0008}, {16'h0020, 16'h0020});
  endtask

  task automatic t_bad_events();
    int cnt;
    // after completion (previous task ended quiet)
    evt_pulse();
    chk("R9 event after done err", 32'(err_o), 32'd1);
    chk("R9 event after done no req", 32'(req_vld_o), 32'd0);
    // during a frame burst of 4
    load_set(3'b100, 32'h500, 32'h600, 16'd1, 16'd4, 16'd1, 16'd0, 32'h0001_0001, 32'h0);
    evt_i = 1'b1;
    @(negedge clk);                    // first array visible
    cnt = int'(req_vld_o);
    evt_i = 1'b1;                      // event mid-burst
    @(negedge clk);
    evt_i = 1'b0;
    chk("R9 event in burst err", 32'(err_o), 32'd1);
    cnt += int'(req_vld_o);
    @(negedge clk);
    cnt += int'(req_vld_o);
    @(negedge clk);
    cnt += int'(req_vld_o);
    chk("R9 burst end done", 32'(done_o), 32'd1);
    chk("R9 burst end src", req_src_o, 32'h503);
    @(negedge clk);
    cnt += int'(req_vld_o);
    chk("R9 burst length unchanged", 32'(cnt), 32'd4);
  endtask

  task automatic t_refuse();
    load_set(3'b000, 32'h0, 32'h0, 16'd4, 16'd0, 16'd1, 16'd1, 32'h0, 32'h0);
    chk("R10 zero arrays err", 32'(err_o), 32'd1);
    evt_pulse();
    chk("R10 zero arrays no req", 32'(req_vld_o), 32'd0);
    load_set(3'b000, 32'h0, 32'h0, 16'd0, 16'd1, 16'd1, 16'd1, 32'h0, 32'h0);
    chk("R10 zero bytes err", 32'(err_o), 32'd1);
    load_set(3'b000, 32'h0, 32'h0, 16'd4, 16'd1, 16'd0, 16'd1, 32'h0, 32'h0);
    chk("R10 zero frames err", 32'(err_o), 32'd1);
    load_set(3'b000, 32'h0, 32'h0, 16'd4, 16'd1, 16'd1, 16'd0, 32'h0, 32'h0);
    chk("R10 zero reload array mode err", 32'(err_o), 32'd1);
    evt_pulse();
    chk("R10 zero reload no req", 32'(req_vld_o), 32'd0);
    load_set(3'b100, 32'h77, 32'h88, 16'd4, 16'd1, 16'd1, 16'd0, 32'h0, 32'h0);
    chk("R10 zero reload frame mode accepted", 32'(err_o), 32'd0);
    evt_pulse();
    chk("R10 frame mode req", 32'(req_vld_o), 32'd1);
    chk("R10 frame mode done", 32'(done_o), 32'd1);
  endtask

  task automatic t_restart();
    load_set(3'b000, 32'h100, 32'h200, 16'd4, 16'd2, 16'd2, 16'd2, 32'h0004_0004, 32'h0);
    evt_pulse();
    chk("R11 first set src", req_src_o, 32'h100);
    load_set(3'b000, 32'h500, 32'h700, 16'd6, 16'd1, 16'd1, 16'd1, 32'h0, 32'h0);
    chk("R11 reload err", 32'(err_o), 32'd0);
    evt_pulse();
    chk("R11 new src", req_src_o, 32'h500);
    chk("R11 new dst", req_dst_o, 32'h700);
    chk("R11 new len", 32'(req_len_o), 32'd6);
    chk("R11 new set done", 32'(done_o), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; ld_i = 1'b0; evt_i = 1'b0; opt_i = '0; src_i = '0; dst_i = '0;
    cnt_ab_i = '0; cnt_c_i = '0; rld_i = '0; ofs_arr_i = '0; ofs_frm_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_array();
    t_frame();
    t_hold();
    t_bad_events();
    t_refuse();
    t_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R3 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule